// File: doc/BRIEF.md
# Cartridge ROM Transfer Sequencer

This block runs one read transaction on a byte-serial cartridge bus. A single control write starts it. It sends an eight-byte command, one byte per transfer cycle. It may then wait out a programmable start gap. After that it collects a programmed number of 32-bit response words from the incoming card byte stream. A further programmable gap is placed in front of every 512-byte block of response data.

Each finished word is parked on a data port and a request flag is raised. The block accepts no more bytes until the host reads the port. That read clears the flag. It then either resumes the transfer or, after the final word, ends the transaction and optionally pulses an interrupt.

The write-direction bit only removes both gaps; the bytes still move through the same byte port. A skip bit decides what happens to card bytes during a gap. When it is set, they are drained and thrown away. When it is clear, they are held off.

Top module: `cart_rom_seq`

## Requirements
- R1: After reset, busy, request, interrupt, card_ready and cmd_strobe are low and data_word is zero.
- R2: A control write with start set, while idle, sends the eight command bytes, byte 0 (cmd_bytes[7:0]) first. There is one cmd_strobe per transfer cycle, and one transfer cycle is 5 clocks when the rate bit is 0 and 8 clocks when it is 1.
- R3: The size code sets the word count: code 0 gives no words, codes 1 to 6 give 128·2^(code−1) words (512·2^(code−1) bytes), and code 7 gives one word.
- R4: Response bytes are packed little-endian: the first byte taken lands in data_word[7:0] and the fourth in [31:24].
- R5: The request flag rises after the fourth byte of a word is taken. While it is high, no byte is accepted, and a data-port read clears it.
- R6: Reading the last word clears busy. A size-0 transfer ends right after the command. On the clock where busy falls, irq pulses for exactly one cycle, and only when the interrupt enable was set.
- R7: In read direction with skip clear, the first data transfer cycle ends (Gs+Gb+1)·L clocks after the last command strobe. Gs is the start gap and Gb is the block gap, both in transfer cycles; a gap of zero takes no time.
- R8: The time from a data-port read to the end of the next word's first byte cycle is (Gb+1)·L clocks when that word starts a new 512-byte block, and L otherwise.
- R9: With the write-direction bit set, neither gap is applied: the first data cycle ends L clocks after the last command strobe.
- R10: With skip set, one card byte per gap transfer cycle is accepted and discarded, so the response word starts Gs+Gb bytes later in the stream. With skip clear, card_ready stays low during gaps.
- R11: If card_valid is low on the last clock of a data transfer cycle, the cycle is held until a byte arrives; no byte is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| ctl_wr | input | 1 | Control-register write strobe |
| ctl_start | input | 1 | Start a transaction |
| ctl_wr_dir | input | 1 | Write direction (suppresses gaps) |
| ctl_skip | input | 1 | Drain card bytes during gaps |
| ctl_slow | input | 1 | Transfer-cycle length select (0: 5 clk, 1: 8 clk) |
| ctl_size | input | 3 | Block-size code |
| ctl_irq_en | input | 1 | Interrupt enable |
| ctl_gap_start | input | GAP_W | Start gap in transfer cycles |
| ctl_gap_blk | input | GAP_W | Per-block gap in transfer cycles |
| cmd_bytes | input | 64 | Eight command bytes, byte 0 in bits 7:0 |
| card_byte | input | 8 | Incoming card byte |
| card_valid | input | 1 | Card byte present |
| card_ready | output | 1 | Card byte taken this clock when valid |
| cmd_byte_out | output | 8 | Current command byte |
| cmd_strobe | output | 1 | Command byte sent this clock |
| data_rd | input | 1 | Data-port read strobe |
| busy | output | 1 | Transaction in progress |
| drq | output | 1 | Word waiting on the data port |
| irq | output | 1 | One-cycle end-of-transfer interrupt |
| data_word | output | 32 | Assembled response word |

## Verification
The bench measures the gap arithmetic by counting clocks. It counts from the last command strobe to the first data cycle, and from each data-port read to the next byte cycle. A design that forgets to skip a zero gap, applies gaps in write direction, or misses the 512-byte boundary is off by a whole multiple of the transfer-cycle length. The host read is held back on purpose to catch a design that fetches the next word early. The card is also made to drop its valid signal, which exposes a design that loses or repeats a byte when a cycle is held. A skip transfer checks that exactly one byte per gap cycle is drained, and a size-0 transfer checks that the interrupt fires with no word ever requested.

// File: rtl/cart_seq_pkg.sv
package cart_seq_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE      = 3'd0,
        SEQ_CMD       = 3'd1,
        SEQ_GAP_START = 3'd2,
        SEQ_GAP_BLOCK = 3'd3,
        SEQ_DATA      = 3'd4,
        SEQ_WAIT      = 3'd5
    } seq_state_e;

endpackage

// File: rtl/cart_xfer_timer.sv
// Transfer-cycle timer: tick on the last clock of every cycle; may hold there.
module cart_xfer_timer #(
    parameter int CYC_FAST = 5,
    parameter int CYC_SLOW = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow,
    input  logic clr,
    input  logic hold,
    output logic tick
);
    localparam int CYC_MAX = (CYC_FAST > CYC_SLOW) ? CYC_FAST : CYC_SLOW;
    localparam int CW      = (CYC_MAX > 1) ? $clog2(CYC_MAX) : 1;

    logic [CW-1:0] cnt_q, cnt_d, last;

    assign last = slow ? CW'(CYC_SLOW - 1) : CW'(CYC_FAST - 1);
    assign tick = (cnt_q == last);

    always_comb begin
        cnt_d = cnt_q + CW'(1);
        if (clr)
            cnt_d = '0;
        else if (tick)
            cnt_d = hold ? cnt_q : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/cart_word_asm.sv
// Little-endian byte-to-word packer.
module cart_word_asm #(
    parameter int WORD_BYTES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    take,
    input  logic [7:0]              in_byte,
    output logic                    done,
    output logic [8*WORD_BYTES-1:0] word_nxt
);
    localparam int WW = 8 * WORD_BYTES;
    localparam int IW = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1;

    logic [WW-1:0] sh_q, sh_d;
    logic [IW-1:0] idx_q, idx_d;

    assign word_nxt = {in_byte, sh_q[WW-1:8]};
    assign done     = take && (idx_q == IW'(WORD_BYTES - 1));

    always_comb begin
        sh_d  = sh_q;
        idx_d = idx_q;
        if (clr) begin
            sh_d  = '0;
            idx_d = '0;
        end else if (take) begin
            sh_d  = word_nxt;
            idx_d = done ? '0 : idx_q + IW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            idx_q <= '0;
        end else begin
            sh_q  <= sh_d;
            idx_q <= idx_d;
        end
    end
endmodule

// File: rtl/cart_size_dec.sv
// Size code to word count: 0 -> none, 1..6 -> one block << (code-1), 7 -> one word.
module cart_size_dec #(
    parameter int BLK_BYTES = 512,
    parameter int WL_W      = 13
) (
    input  logic [2:0]      code,
    output logic [WL_W-1:0] words
);
    localparam int WPB = BLK_BYTES / 4;

    always_comb begin
        unique case (code)
            3'd0:    words = '0;
            3'd7:    words = WL_W'(1);
            default: words = WL_W'(WPB) << (code - 3'd1);
        endcase
    end
endmodule

// File: rtl/cart_rom_seq.sv
module cart_rom_seq
    import cart_seq_pkg::*;
#(
    parameter int CYC_FAST  = 5,
    parameter int CYC_SLOW  = 8,
    parameter int GAP_W     = 13,
    parameter int BLK_BYTES = 512,
    parameter int CMD_BYTES = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ctl_wr,
    input  logic                   ctl_start,
    input  logic                   ctl_wr_dir,
    input  logic                   ctl_skip,
    input  logic                   ctl_slow,
    input  logic [2:0]             ctl_size,
    input  logic                   ctl_irq_en,
    input  logic [GAP_W-1:0]       ctl_gap_start,
    input  logic [GAP_W-1:0]       ctl_gap_blk,
    input  logic [8*CMD_BYTES-1:0] cmd_bytes,
    input  logic [7:0]             card_byte,
    input  logic                   card_valid,
    output logic                   card_ready,
    output logic [7:0]             cmd_byte_out,
    output logic                   cmd_strobe,
    input  logic                   data_rd,
    output logic                   busy,
    output logic                   drq,
    output logic                   irq,
    output logic [31:0]            data_word
);
    localparam int WPB    = BLK_BYTES / 4;
    localparam int WIB_W  = (WPB > 1) ? $clog2(WPB) : 1;
    localparam int WL_W   = $clog2(WPB << 5) + 1;
    localparam int CIDX_W = (CMD_BYTES > 1) ? $clog2(CMD_BYTES) : 1;

    typedef struct packed {
        seq_state_e             state;
        logic [CIDX_W-1:0]      cmd_idx;
        logic [GAP_W-1:0]       gap_cnt;
        logic [WL_W-1:0]        words_left;
        logic [WIB_W-1:0]       wib;
        logic                   drq;
        logic                   irq;
        logic [31:0]            data;
        logic [8*CMD_BYTES-1:0] cmd;
        logic                   slow;
        logic                   wr_dir;
        logic                   skip;
        logic                   irq_en;
        logic [GAP_W-1:0]       gap_s;
        logic [GAP_W-1:0]       gap_b;
    } seq_regs_t;

    seq_regs_t r_q, r_d;

    logic            tick, tmr_clr, tmr_hold;
    logic            asm_clr, take, asm_done;
    logic [31:0]     asm_word;
    logic [WL_W-1:0] dec_words;
    logic            gs_on, gb_on, in_gap;

    cart_xfer_timer #(.CYC_FAST(CYC_FAST), .CYC_SLOW(CYC_SLOW)) u_timer (
        .clk(clk), .rst_n(rst_n), .slow(r_q.slow),
        .clr(tmr_clr), .hold(tmr_hold), .tick(tick)
    );

    cart_word_asm #(.WORD_BYTES(4)) u_asm (
        .clk(clk), .rst_n(rst_n), .clr(asm_clr), .take(take),
        .in_byte(card_byte), .done(asm_done), .word_nxt(asm_word)
    );

    cart_size_dec #(.BLK_BYTES(BLK_BYTES), .WL_W(WL_W)) u_dec (
        .code(ctl_size), .words(dec_words)
    );

    assign gs_on    = !r_q.wr_dir && (r_q.gap_s != '0);
    assign gb_on    = !r_q.wr_dir && (r_q.gap_b != '0);
    assign in_gap   = (r_q.state == SEQ_GAP_START) || (r_q.state == SEQ_GAP_BLOCK);
    assign tmr_hold = (r_q.state == SEQ_DATA) && !card_valid;
    assign take     = (r_q.state == SEQ_DATA) && tick && card_valid;

    assign card_ready   = ((r_q.state == SEQ_DATA) && tick) || (in_gap && r_q.skip && tick);
    assign cmd_strobe   = (r_q.state == SEQ_CMD) && tick;
    assign cmd_byte_out = r_q.cmd[{r_q.cmd_idx, 3'b000} +: 8];
    assign busy         = (r_q.state != SEQ_IDLE);
    assign drq          = r_q.drq;
    assign irq          = r_q.irq;
    assign data_word    = r_q.data;

    always_comb begin
        r_d     = r_q;
        r_d.irq = 1'b0;
        tmr_clr = 1'b0;
        asm_clr = 1'b0;

        unique case (r_q.state)
            SEQ_IDLE: begin
                if (ctl_wr && ctl_start) begin
                    r_d.state      = SEQ_CMD;
                    r_d.cmd_idx    = '0;
                    r_d.gap_cnt    = '0;
                    r_d.wib        = '0;
                    r_d.words_left = dec_words;
                    r_d.cmd        = cmd_bytes;
                    r_d.slow       = ctl_slow;
                    r_d.wr_dir     = ctl_wr_dir;
                    r_d.skip       = ctl_skip;
                    r_d.irq_en     = ctl_irq_en;
                    r_d.gap_s      = ctl_gap_start;
                    r_d.gap_b      = ctl_gap_blk;
                    tmr_clr        = 1'b1;
                    asm_clr        = 1'b1;
                end
            end

            SEQ_CMD: begin
                if (tick) begin
                    if (r_q.cmd_idx == CIDX_W'(CMD_BYTES - 1)) begin
                        if (r_q.words_left == '0) begin
                            r_d.state = SEQ_IDLE;
                            r_d.irq   = r_q.irq_en;
                        end else if (gs_on) begin
                            r_d.state = SEQ_GAP_START;
                        end else if (gb_on) begin
                            r_d.state = SEQ_GAP_BLOCK;
                        end else begin
                            r_d.state = SEQ_DATA;
                        end
                    end else begin
                        r_d.cmd_idx = r_q.cmd_idx + CIDX_W'(1);
                    end
                end
            end

            SEQ_GAP_START: begin
                if (tick) begin
                    if (r_q.gap_cnt == r_q.gap_s - GAP_W'(1)) begin
                        r_d.gap_cnt = '0;
                        r_d.state   = gb_on ? SEQ_GAP_BLOCK : SEQ_DATA;
                    end else begin
                        r_d.gap_cnt = r_q.gap_cnt + GAP_W'(1);
                    end
                end
            end

            SEQ_GAP_BLOCK: begin
                if (tick) begin
                    if (r_q.gap_cnt == r_q.gap_b - GAP_W'(1)) begin
                        r_d.gap_cnt = '0;
                        r_d.state   = SEQ_DATA;
                    end else begin
                        r_d.gap_cnt = r_q.gap_cnt + GAP_W'(1);
                    end
                end
            end

            SEQ_DATA: begin
                if (take && asm_done) begin
                    r_d.state      = SEQ_WAIT;
                    r_d.drq        = 1'b1;
                    r_d.data       = asm_word;
                    r_d.words_left = r_q.words_left - WL_W'(1);
                    r_d.wib        = r_q.wib + WIB_W'(1);
                end
            end

            SEQ_WAIT: begin
                tmr_clr = 1'b1;
                if (data_rd) begin
                    r_d.drq = 1'b0;
                    if (r_q.words_left == '0) begin
                        r_d.state = SEQ_IDLE;
                        r_d.irq   = r_q.irq_en;
                    end else if ((r_q.wib == '0) && gb_on) begin
                        r_d.state = SEQ_GAP_BLOCK;
                    end else begin
                        r_d.state = SEQ_DATA;
                    end
                end
            end

            default: r_d.state = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/cart_rom_seq_chk.sv
module cart_rom_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        card_ready,
    input logic        card_valid,
    input logic        cmd_strobe,
    input logic        data_rd,
    input logic        busy,
    input logic        drq,
    input logic        irq,
    input logic [31:0] data_word
);
    assert_ready_in_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        card_ready |-> busy);

    assert_strobe_in_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_strobe |-> busy);

    assert_no_take_while_drq_R5: assert property (@(posedge clk) disable iff (!rst_n)
        drq |-> !card_ready);

    assert_drq_falls_on_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drq) |-> $past(data_rd));

    assert_drq_after_take_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drq) |-> $past(card_ready && card_valid));

    assert_word_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (drq && $past(drq)) |-> $stable(data_word));

    assert_irq_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    assert_irq_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $fell(busy));
endmodule

bind cart_rom_seq cart_rom_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .card_ready(card_ready), .card_valid(card_valid),
    .cmd_strobe(cmd_strobe), .data_rd(data_rd), .busy(busy), .drq(drq),
    .irq(irq), .data_word(data_word)
);

// File: tb/cart_rom_seq_tb.sv
module cart_rom_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0, ctl_start = 1'b0, ctl_wr_dir = 1'b0, ctl_skip = 1'b0;
    logic        ctl_slow = 1'b0, ctl_irq_en = 1'b0;
    logic [2:0]  ctl_size = '0;
    logic [12:0] ctl_gap_start = '0, ctl_gap_blk = '0;
    logic [63:0] cmd_bytes = '0;
    logic [7:0]  card_byte = '0;
    logic        card_valid = 1'b1;
    logic        card_ready, cmd_strobe, busy, drq, irq;
    logic [7:0]  cmd_byte_out;
    logic        data_rd = 1'b0;
    logic [31:0] data_word;

    always #5 clk = ~clk;

    cart_rom_seq u_dut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_start(ctl_start),
        .ctl_wr_dir(ctl_wr_dir), .ctl_skip(ctl_skip), .ctl_slow(ctl_slow),
        .ctl_size(ctl_size), .ctl_irq_en(ctl_irq_en), .ctl_gap_start(ctl_gap_start),
        .ctl_gap_blk(ctl_gap_blk), .cmd_bytes(cmd_bytes), .card_byte(card_byte),
        .card_valid(card_valid), .card_ready(card_ready), .cmd_byte_out(cmd_byte_out),
        .cmd_strobe(cmd_strobe), .data_rd(data_rd), .busy(busy), .drq(drq),
        .irq(irq), .data_word(data_word)
    );

    int n_chk = 0, n_bad = 0;
    int src_idx = 0, ncyc = 0, vcnt = 0;
    bit take_pend = 0, stall_mode = 0;
    logic [31:0] exp_q[$];
    int cur_l = 5, cur_ien = 0, rd_hold = 0;
    int cmd_seen, prev_cmd_t, last_cmd_t, first_delay, nread, rd_t, irq_cnt, hold;
    bit want_first, want_rd, got, end_pend, stall_bad;
    int delays[0:511];

    function automatic logic [7:0] fb(input int k);
        return 8'((k * 73 + 19) & 255);
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // card byte source: one byte consumed per accepted handshake
    initial begin
        forever begin
            @(negedge clk);
            if (take_pend) src_idx++;
            card_byte = fb(src_idx);
            vcnt++;
            card_valid = stall_mode ? ((vcnt % 3) != 0) : 1'b1;
            take_pend = card_ready && card_valid;
        end
    end

    // monitor: command bytes, gap timing, scoreboard pops and data-port reads
    initial begin
        forever begin
            @(negedge clk);
            ncyc++;
            if (cmd_strobe) begin
                check(cmd_byte_out == cmd_bytes[cmd_seen*8 +: 8], "R2 command byte order",
                      cmd_byte_out, cmd_bytes[cmd_seen*8 +: 8]);
                if (cmd_seen > 0)
                    check(ncyc - prev_cmd_t == cur_l, "R2 strobe spacing", ncyc - prev_cmd_t, cur_l);
                prev_cmd_t = ncyc;
                cmd_seen++;
                if (cmd_seen == 8) begin
                    last_cmd_t = ncyc;
                    want_first = 1;
                end
            end
            if (card_ready && want_first) begin
                first_delay = ncyc - last_cmd_t;
                want_first = 0;
            end
            if (card_ready && want_rd) begin
                if (nread >= 1 && nread <= 512) delays[nread-1] = ncyc - rd_t;
                want_rd = 0;
            end
            if (irq) irq_cnt++;
            if (data_rd) begin
                data_rd = 1'b0;
                if (end_pend) begin
                    check(!busy, "R6 busy clears on last read", busy, 0);
                    check(irq == 1'(cur_ien), "R6 irq on last read", irq, cur_ien);
                    end_pend = 0;
                end
            end else if (drq) begin
                if (!got) begin
                    if (exp_q.size() == 0) begin
                        check(0, "R3 unexpected extra word", data_word, 0);
                    end else begin
                        logic [31:0] e;
                        e = exp_q.pop_front();
                        check(data_word == e, "R4 word value", data_word, e);
                        end_pend = (exp_q.size() == 0);
                    end
                    got = 1;
                    hold = rd_hold;
                end
                if (hold > 0) begin
                    if (card_ready) stall_bad = 1;
                    hold--;
                end else begin
                    data_rd = 1'b1;
                    rd_t = ncyc;
                    nread++;
                    got = 0;
                    want_rd = 1;
                end
            end
        end
    end

    task automatic start_xfer(input logic [2:0] code, input bit slow, input bit wr, input bit skip,
                              input bit ien, input int gs, input int gb, input logic [63:0] cmd);
        int nw, base;
        nw = (code == 0) ? 0 : (code == 7) ? 1 : (128 << (code - 1));
        base = src_idx + ((skip && !wr) ? gs + gb : 0);
        for (int w = 0; w < nw; w++)
            exp_q.push_back({fb(base + 4*w + 3), fb(base + 4*w + 2), fb(base + 4*w + 1), fb(base + 4*w)});
        cur_l = slow ? 8 : 5;
        cur_ien = ien;
        cmd_seen = 0; nread = 0; irq_cnt = 0; first_delay = -1;
        want_first = 0; want_rd = 0; got = 0; end_pend = 0; stall_bad = 0;
        for (int i = 0; i < 512; i++) delays[i] = -1;
        @(negedge clk);
        cmd_bytes = cmd; ctl_size = code; ctl_slow = slow; ctl_wr_dir = wr;
        ctl_skip = skip; ctl_irq_en = ien;
        ctl_gap_start = 13'(gs); ctl_gap_blk = 13'(gb);
        ctl_start = 1'b1; ctl_wr = 1'b1;
        @(negedge clk);
        ctl_wr = 1'b0; ctl_start = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int s0;
        bit ok;
        repeat (4) @(negedge clk);
        // R1 reset state
        check(!busy && !drq && !irq && !card_ready && !cmd_strobe, "R1 reset outputs",
              {busy, drq, irq, card_ready, cmd_strobe}, 0);
        check(data_word == 0, "R1 reset word", data_word, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // T2: one word, both gaps, delayed read, irq enabled
        rd_hold = 15;
        start_xfer(3'd7, 0, 0, 0, 1, 3, 2, 64'h8877_6655_4433_2211);
        wait_idle();
        rd_hold = 0;
        check(cmd_seen == 8, "R2 command count", cmd_seen, 8);
        check(first_delay == 30, "R7 start plus block gap", first_delay, 30);
        check(nread == 1 && exp_q.size() == 0, "R3 code 7 one word", nread, 1);
        check(!stall_bad, "R5 no take while request pending", stall_bad, 0);
        check(irq_cnt == 1, "R6 irq enabled", irq_cnt, 1);

        // T3: code 1, slow cycles, zero start gap, irq disabled
        start_xfer(3'd1, 1, 0, 0, 0, 0, 4, 64'h0F1E_2D3C_4B5A_6978);
        wait_idle();
        check(nread == 128 && exp_q.size() == 0, "R3 code 1 word count", nread, 128);
        check(first_delay == 40, "R7 zero start gap skipped", first_delay, 40);
        ok = 1;
        for (int i = 0; i < 127; i++) if (delays[i] != 8) ok = 0;
        check(ok, "R8 no gap inside block", delays[0], 8);
        check(irq_cnt == 0, "R6 irq disabled", irq_cnt, 0);

        // T4: code 2, block gap at 512-byte boundary
        start_xfer(3'd2, 0, 0, 0, 1, 1, 3, 64'hDEAD_BEEF_CAFE_F00D);
        wait_idle();
        check(nread == 256 && exp_q.size() == 0, "R3 code 2 word count", nread, 256);
        check(first_delay == 25, "R7 gaps before first block", first_delay, 25);
        check(delays[127] == 20, "R8 gap at block boundary", delays[127], 20);
        check(delays[0] == 5 && delays[200] == 5, "R8 no gap mid block", delays[200], 5);

        // T5: write direction suppresses both gaps
        start_xfer(3'd7, 1, 1, 0, 0, 6, 6, 64'h1234_5678_9ABC_DEF0);
        wait_idle();
        check(first_delay == 8, "R9 no gaps in write direction", first_delay, 8);
        check(nread == 1, "R9 word moved", nread, 1);

        // T6: skip drains one byte per gap cycle
        s0 = src_idx;
        start_xfer(3'd7, 0, 0, 1, 0, 2, 3, 64'h0102_0304_0506_0708);
        wait_idle();
        check(src_idx - s0 == 9, "R10 bytes drained in gaps", src_idx - s0, 9);
        check(nread == 1 && exp_q.size() == 0, "R10 word after drain", nread, 1);

        // T7: card stalls mid-cycle
        stall_mode = 1;
        s0 = src_idx;
        start_xfer(3'd1, 0, 0, 0, 1, 0, 0, 64'hA5A5_5A5A_3C3C_C3C3);
        wait_idle();
        stall_mode = 0;
        check(nread == 128 && exp_q.size() == 0, "R11 all words under stall", nread, 128);
        check(src_idx - s0 == 512, "R11 no byte lost or repeated", src_idx - s0, 512);

        // T8: size 0 ends after command
        s0 = src_idx;
        start_xfer(3'd0, 0, 0, 0, 1, 2, 2, 64'hFFEE_DDCC_BBAA_9988);
        wait_idle();
        check(cmd_seen == 8 && nread == 0, "R3 code 0 no words", nread, 0);
        check(irq_cnt == 1, "R6 irq after empty transfer", irq_cnt, 1);
        check(src_idx == s0, "R10 no card byte taken", src_idx - s0, 0);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule